// File: doc/BRIEF.md
# Two-Landing Lift Controller

This block sequences a lift car that serves two landings. Requests arrive from hall call buttons and from the buttons inside the car. Each request sets a pending flag for its landing, and the flag holds until the controller clears it after serving that landing. The landing switches report where the car stands. The controller drives an up command and a down command to the motor, and a one-cycle door-open command. The door reports back through a closed-status input.

The sequencer has four states: parked at the lower landing, rising, parked at the upper landing, and falling. A parked car first serves a request for its own landing by opening the door. It leaves for the other landing only while the door reports closed. It stops on the rising edge of the destination's landing switch.

The reset input is asynchronous and active low. Its release passes through a synchronizer, so the outputs are low both during reset and while the release propagates.

Top module: `lift2_ctrl`

## Requirements
- R1: While rst_n is low, and for as long as no request is made after its release, motor_up, motor_down and door_open are all 0. A button pressed only while reset is asserted leaves no pending request.
- R2: A one-cycle press for the other landing, with door_closed = 1, turns on the motor for that direction in the second cycle after the press cycle.
- R3: A pending trip does not start while door_closed = 0. The motor turns on in the cycle after the first cycle in which door_closed = 1.
- R4: The motor command stays on until the destination's landing_sw bit rises. In that same cycle the motor command is 0 and door_open is 1.
- R5: In the cycle after an arrival, with no new press, door_open and both motor commands are 0, because the served request has been cleared.
- R6: motor_up is used only for trips to the upper landing and motor_down only for trips to the lower landing. The two are never 1 together, and neither is 1 while door_open is 1.
- R7: A request for the landing where the car is parked gives door_open = 1 for exactly one cycle, in the cycle after the press, and no motor command.
- R8: If a press for a landing is sampled in the same cycle as that landing's clear, the press wins. door_open is then 1 again in the cycle after arrival, and 0 in the cycle after that.
- R9: Hall and car buttons have the same effect. In every 2-bit vector, bit 0 is the lower landing and bit 1 is the upper landing.
- R10: While the car is moving, landing_sw changes other than a rising edge on the destination bit do not affect the motor command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hall_call | input | 2 | Hall call buttons (bit 0 lower, bit 1 upper) |
| car_btn | input | 2 | In-car landing buttons (bit 0 lower, bit 1 upper) |
| landing_sw | input | 2 | Landing switches, 1 while the car is at that landing |
| door_closed | input | 1 | 1 when the door is closed |
| motor_up | output | 1 | Motor up command |
| motor_down | output | 1 | Motor down command |
| door_open | output | 1 | Door-open command |

## Verification
Outputs are decoded combinationally from the registered state and the pending flags, with one exception: the arrival response also uses the live landing switch.
- **Arrival (R4):** the stop and door-open are due in the same cycle that landing_sw rises.
- **Press to response:** a press is latched at one edge and acted on in the following cycle. So an own-landing door-open is due one cycle after the press cycle, and a departure two cycles after it.
- **Door-closed wait (R3):** a departure delayed by door_closed moves out by exactly the number of closed-door wait cycles.

The bench drives inputs just after the falling clock edge and checks 1 ns later. Each check therefore sees the state left by the preceding rising edge combined with the inputs it has just applied. The bench sweeps button source, door delay and the clear/set collision through round trips.

// File: rtl/lift2_pkg.sv
package lift2_pkg;
  localparam int unsigned LANDINGS    = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned LO          = 0;
  localparam int unsigned HI          = 1;

  typedef enum logic [1:0] {
    ST_PARK_LO = 2'd0,
    ST_RISE    = 2'd1,
    ST_PARK_HI = 2'd2,
    ST_FALL    = 2'd3
  } lift_state_e;

  typedef struct packed {
    logic up;
    logic down;
    logic door;
  } lift_cmd_t;
endpackage

// File: rtl/lift2_rst_sync.sv
module lift2_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lift2_req_latch.sv
module lift2_req_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;

    // set dominates clear
    always_comb begin
      flag_en = set_vec[g] | clr_vec[g];
      flag_d  = set_vec[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign pend[g] = flag_q;
  end
endmodule

// File: rtl/lift2_seq.sv
module lift2_seq
  import lift2_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANDINGS-1:0] pend,
  input  logic [LANDINGS-1:0] landing_sw,
  input  logic                door_closed,
  output lift_cmd_t           cmd,
  output logic [LANDINGS-1:0] clr_vec
);
  lift_state_e         state_q;
  lift_state_e         state_d;
  logic                state_en;
  logic [LANDINGS-1:0] sw_q;
  logic [LANDINGS-1:0] arrive;

  assign arrive = landing_sw & ~sw_q;

  always_comb begin
    state_d  = state_q;
    cmd      = '0;
    clr_vec  = '0;
    unique case (state_q)
      ST_PARK_LO: begin
        if (pend[LO]) begin
          clr_vec[LO] = 1'b1;
          cmd.door    = 1'b1;
        end else if (pend[HI] && door_closed) begin
          state_d = ST_RISE;
        end
      end
      ST_RISE: begin
        if (arrive[HI]) begin
          state_d     = ST_PARK_HI;
          clr_vec[HI] = 1'b1;
          cmd.door    = 1'b1;
        end else begin
          cmd.up = 1'b1;
        end
      end
      ST_PARK_HI: begin
        if (pend[HI]) begin
          clr_vec[HI] = 1'b1;
          cmd.door    = 1'b1;
        end else if (pend[LO] && door_closed) begin
          state_d = ST_FALL;
        end
      end
      ST_FALL: begin
        if (arrive[LO]) begin
          state_d     = ST_PARK_LO;
          clr_vec[LO] = 1'b1;
          cmd.door    = 1'b1;
        end else begin
          cmd.down = 1'b1;
        end
      end
      default: state_d = ST_PARK_LO;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_PARK_LO;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= landing_sw;
  end
endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl
  import lift2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hall_call,
  input  logic [1:0] car_btn,
  input  logic [1:0] landing_sw,
  input  logic       door_closed,
  output logic       motor_up,
  output logic       motor_down,
  output logic       door_open
);
  logic                rst_core_n;
  logic [LANDINGS-1:0] req_set;
  logic [LANDINGS-1:0] req_clr;
  logic [LANDINGS-1:0] req_pend;
  lift_cmd_t           cmd;

  lift2_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign req_set = hall_call | car_btn;

  lift2_req_latch #(.N(LANDINGS)) u_req (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_vec (req_set),
    .clr_vec (req_clr),
    .pend    (req_pend)
  );

  lift2_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pend        (req_pend),
    .landing_sw  (landing_sw),
    .door_closed (door_closed),
    .cmd         (cmd),
    .clr_vec     (req_clr)
  );

  assign motor_up   = cmd.up;
  assign motor_down = cmd.down;
  assign door_open  = cmd.door;
endmodule

// File: rtl/lift2_ctrl_chk.sv
module lift2_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] landing_sw,
  input logic       door_closed,
  input logic       motor_up,
  input logic       motor_down,
  input logic       door_open
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!motor_up && !motor_down && !door_open));

  // R6
  motor_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(motor_up && motor_down));

  // R6
  door_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    door_open |-> (!motor_up && !motor_down));

  // R3
  up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_up) |-> $past(door_closed));

  // R3
  down_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_down) |-> $past(door_closed));

  // R4
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    motor_up |=> (motor_up || door_open));

  // R4
  down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    motor_down |=> (motor_down || door_open));

  // R7
  door_at_landing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    door_open |-> (landing_sw != 2'b00));
endmodule

bind lift2_ctrl lift2_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .landing_sw  (landing_sw),
  .door_closed (door_closed),
  .motor_up    (motor_up),
  .motor_down  (motor_down),
  .door_open   (door_open)
);

// File: tb/lift2_ctrl_tb_top.sv
`timescale 1ns/100ps
module lift2_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] hall_call;
  logic [1:0] car_btn;
  logic [1:0] landing_sw;
  logic       door_closed;
  logic       motor_up;
  logic       motor_down;
  logic       door_open;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lift2_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hall_call   (hall_call),
    .car_btn     (car_btn),
    .landing_sw  (landing_sw),
    .door_closed (door_closed),
    .motor_up    (motor_up),
    .motor_down  (motor_down),
    .door_open   (door_open)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic press(input int src, input int f, input bit v);
    if (src == 0) hall_call[f] = v;
    else          car_btn[f]   = v;
  endtask

  function automatic int mover(input int tgt);
    return (tgt == 1) ? int'(motor_up) : int'(motor_down);
  endfunction

  function automatic int other(input int tgt);
    return (tgt == 1) ? int'(motor_down) : int'(motor_up);
  endfunction

  // one trip to landing tgt, then an own-landing request there
  task automatic trip(input int tgt, input int src, input int dcw, input bit prio);
    int from = 1 - tgt;
    @(negedge clk);
    press(src, tgt, 1'b1);
    door_closed = (dcw == 0);
    #1 chk("R2 no motion in press cycle", mover(tgt), 0);
    @(negedge clk);
    press(src, tgt, 1'b0);
    #1 chk("R2 no motion one cycle after press", mover(tgt), 0);
    for (int i = 0; i < dcw; i++) begin
      @(negedge clk);
      #1 chk("R3 held while door open", mover(tgt), 0);
    end
    door_closed = 1'b1;
    @(negedge clk);
    #1 chk("R2 R3 motor on after departure edge", mover(tgt), 1);
    chk("R6 opposite motor off", other(tgt), 0);
    landing_sw[from] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      landing_sw[from] = (k == 1);
      #1 chk("R10 motor kept while travelling", mover(tgt), 1);
      chk("R6 opposite motor off in travel", other(tgt), 0);
    end
    landing_sw[from] = 1'b0;
    @(negedge clk);
    landing_sw[tgt] = 1'b1;
    door_closed = 1'b0;
    if (prio) press(src, tgt, 1'b1);
    #1 chk("R4 motor drops on arrival", mover(tgt), 0);
    chk("R4 door opens on arrival", int'(door_open), 1);
    @(negedge clk);
    press(src, tgt, 1'b0);
    #1;
    if (prio) begin
      chk("R8 set wins, door reopens", int'(door_open), 1);
      @(negedge clk);
      #1;
    end
    chk("R5 door pulse ends", int'(door_open), 0);
    chk("R5 motors idle after arrival", int'(motor_up | motor_down), 0);
    // own-landing request (R7, R9 through src)
    @(negedge clk);
    press(src, tgt, 1'b1);
    #1 chk("R7 no door in press cycle", int'(door_open), 0);
    @(negedge clk);
    press(src, tgt, 1'b0);
    #1 chk("R7 door opens for own landing", int'(door_open), 1);
    chk("R7 no motor for own landing", int'(motor_up | motor_down), 0);
    @(negedge clk);
    #1 chk("R7 door pulse is one cycle", int'(door_open), 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    hall_call   = 2'b00;
    car_btn     = 2'b00;
    landing_sw  = 2'b01;
    door_closed = 1'b1;
    @(negedge clk);
    car_btn[1] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 chk("R1 outputs low in reset", int'({motor_up, motor_down, door_open}), 0);
    end
    car_btn[1] = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1 chk("R1 no request survives reset", int'({motor_up, motor_down, door_open}), 0);
    end
    for (int src = 0; src < 2; src++)
      for (int dcw = 0; dcw < 4; dcw++)
        for (int p = 0; p < 2; p++) begin
          trip(1, src, dcw, p[0]);
          trip(0, src, dcw, p[0]);
        end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule